// File: doc/BRIEF.md
# Pulse-Width Coded Single-Line Serial Transmitter

This block sends a frame of bits over one output line. Each bit gets a fixed period of P system clocks, and the bit value is carried by the duty cycle within that period. Every period starts with a rising edge. A zero holds the line high for about a fifth of the period. A one holds it high for about four fifths. The rest of the period is low. A receiver that samples the line halfway through each period after the rising edge recovers the bit.

A host presents a data word, a bit count and a period in clocks, then pulses start for one cycle. The block captures all three values and sends the selected bits one after another with no gap between them, so the line never rests long enough to trip a receiver inactivity timeout. It raises busy for the length of the frame. When the low phase of the last bit ends, it pulses done for one clock. The line rests low between frames. Since the period is a runtime value, a single build can serve any bit rate inside the receiver's allowed window, for example 60 to 80 kHz.

Top module: `pwidth_line_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, line_o, busy_o and done_o are all 0.
- R2: A start pulse is accepted when busy_o is 0, nbits_i is between 1 and DATA_W and period_i is at least 5. In the cycle after the accepting clock edge, busy_o is 1 and line_o is 1.
- R3: A start pulse is ignored in three cases: busy_o is 1, nbits_i is 0 or greater than DATA_W, or period_i is below 5. An ignored pulse while idle leaves busy_o and line_o at 0. An ignored pulse during a frame leaves that frame's waveform unchanged.
- R4: Each bit lasts exactly P clock cycles, where P is the captured period. Each bit starts with the line going high, and the bits follow each other back to back.
- R5: A bit of value 0 keeps line_o high for floor(P/5) cycles and then low for the rest of its period.
- R6: A bit of value 1 keeps line_o high for P - floor(P/5) cycles and then low for the rest of its period.
- R7: With a bit count N, the block sends data bits N-1 down to 0 in that order, highest first. Data bits at index N and above have no effect.
- R8: In the cycle right after the final bit's period ends, done_o is 1 for exactly one cycle, busy_o is 0 and line_o is 0.
- R9: The data, bit count and period are captured on the accepting edge. Changing those inputs during a frame does not alter the frame.
- R10: line_o is 0 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to send a frame |
| data_i | input | DATA_W | Frame bits; the low nbits_i bits are sent, highest first |
| nbits_i | input | CNT_W | Number of bits in the frame |
| period_i | input | DIV_W | Bit period in system clocks |
| line_o | output | 1 | Pulse-width coded serial line |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse when the frame ends |

## Verification
The assertions assume that reset is applied at power-up, so they do not check any state from before the first reset. They also assume the host only asks for frames with a period of 5 or more clocks. The threshold ordering and the rising edge at each bit start depend on that. The stimulus sends legal frames with random periods from 5 to 40 and random bit counts and data. It separately drives the illegal bit counts and short periods, which the block must ignore. Between accepted frames it randomizes the inputs and pulses start in the middle of a frame, so the capture and ignore rules are exercised against real traffic.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  // Shortest accepted bit period in system clocks.
  localparam int unsigned MIN_PERIOD = 5;
  // Short phase is one part in HIGH_DIV of the period.
  localparam int unsigned HIGH_DIV   = 5;
endpackage

// File: rtl/pwtx_shifter.sv
module pwtx_shifter #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              last_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  align;

  // Move the selected low bits to the top so the shift always leaves from the MSB.
  assign align = FULL - nbits_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= data_i << align;
      left_q <= nbits_i;
    end else if (shift_i) begin
      sr_q   <= sr_q << 1;
      left_q <= left_q - ONE;
    end
  end

  assign msb_o  = sr_q[DATA_W-1];
  assign last_o = (left_q == ONE);

  // R4: bits are only advanced while at least two remain.
  assert_shift_live_R4: assert property (@(posedge clk) disable iff (rst)
    shift_i |-> (left_q > ONE));
endmodule

// File: rtl/pwtx_timer.sv
module pwtx_timer
  import pwtx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DIV_W-1:0] period_i,
  input  logic             run_i,
  input  logic             bit_i,
  output logic             bit_end_o,
  output logic             phase_zero_o,
  output logic             stay_high_o
);
  localparam logic [DIV_W-1:0] DIVISOR = DIV_W'(HIGH_DIV);
  localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

  logic [DIV_W-1:0] per_q;
  logic [DIV_W-1:0] hi_zero_q;
  logic [DIV_W-1:0] hi_one_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] short_len;
  logic [DIV_W:0]   cnt_next;
  logic [DIV_W-1:0] thr;

  assign short_len = period_i / DIVISOR;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q     <= '0;
      hi_zero_q <= '0;
      hi_one_q  <= '0;
      cnt_q     <= '0;
    end else if (load_i) begin
      per_q     <= period_i;
      hi_zero_q <= short_len;
      hi_one_q  <= period_i - short_len;
      cnt_q     <= '0;
    end else if (run_i) begin
      cnt_q <= bit_end_o ? '0 : cnt_q + ONE;
    end
  end

  assign bit_end_o    = run_i && (cnt_q == per_q - ONE);
  assign phase_zero_o = (cnt_q == '0);
  assign thr          = bit_i ? hi_one_q : hi_zero_q;
  assign cnt_next     = {1'b0, cnt_q} + {{DIV_W{1'b0}}, 1'b1};
  assign stay_high_o  = cnt_next < {1'b0, thr};

  // R4: the phase counter stays inside the captured period.
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt_q < per_q));
  // R9: the captured period does not move during a frame.
  assert_period_held_R9: assert property (@(posedge clk) disable iff (rst)
    (run_i && !load_i) |=> $stable(per_q));
  // R5: the zero high phase is nonzero and shorter than the one high phase.
  assert_thr_order_R5: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (hi_zero_q != '0) && (hi_zero_q < hi_one_q));
endmodule

// File: rtl/pwidth_line_tx.sv
module pwidth_line_tx
  import pwtx_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 1),
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic [DIV_W-1:0]  period_i,
  output logic              line_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] MAX_BITS = CNT_W'(DATA_W);
  localparam logic [DIV_W-1:0] MIN_PER  = DIV_W'(MIN_PERIOD);

  tx_state_e state_q;
  logic      line_q;
  logic      done_q;
  logic      accept;
  logic      running;
  logic      msb;
  logic      last;
  logic      bit_end;
  logic      phase_zero;
  logic      stay_high;

  assign running = (state_q == ST_SEND);
  assign accept  = start_i && !running && (nbits_i != '0) &&
                   (nbits_i <= MAX_BITS) && (period_i >= MIN_PER);

  pwtx_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .load_i  (accept),
    .data_i  (data_i),
    .nbits_i (nbits_i),
    .shift_i (bit_end && !last),
    .msb_o   (msb),
    .last_o  (last)
  );

  pwtx_timer #(.DIV_W(DIV_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .load_i       (accept),
    .period_i     (period_i),
    .run_i        (running),
    .bit_i        (msb),
    .bit_end_o    (bit_end),
    .phase_zero_o (phase_zero),
    .stay_high_o  (stay_high)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      line_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_SEND;
        line_q  <= 1'b1;
      end else if (running) begin
        if (bit_end) begin
          if (last) begin
            state_q <= ST_IDLE;
            line_q  <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            line_q <= 1'b1;
          end
        end else begin
          line_q <= stay_high;
        end
      end
    end
  end

  assign line_o = line_q;
  assign busy_o = running;
  assign done_o = done_q;

  // R10: the line rests low outside a frame.
  assert_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !line_o);
  // R8: done is a single-cycle pulse.
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8: done appears only as a frame closes.
  assert_done_closes_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));
  // R4: rising edges occur only at the first clock of a bit period.
  assert_rise_at_start_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $rose(line_o)) |-> phase_zero);
  // R4: a frame never stops in the middle of a bit.
  assert_no_early_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !bit_end) |=> busy_o);
endmodule

// File: tb/test_pwidth_line_tx.sv
module test_pwidth_line_tx;
  localparam int DW = 16;
  localparam int CW = $clog2(DW + 1);
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [CW-1:0] nbits_i = '0;
  logic [PW-1:0] period_i = '0;
  logic          line_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwidth_line_tx #(.DATA_W(DW), .CNT_W(CW), .DIV_W(PW)) i_pwidth_line_tx (
    .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i),
    .nbits_i(nbits_i), .period_i(period_i),
    .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int high_len(input bit b, input int p);
    return b ? (p - p / 5) : (p / 5);
  endfunction

  // Sends one legal frame and compares every cycle of the waveform.
  task automatic run_frame(input logic [DW-1:0] d, input int n, input int p);
    int bad = 0;
    int first_act = 0;
    int first_exp = 0;
    @(negedge clk);
    data_i = d; nbits_i = CW'(n); period_i = PW'(p); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    data_i = DW'($urandom); nbits_i = CW'($urandom_range(1, DW));
    period_i = PW'($urandom_range(5, 60));   // R9: inputs disturbed after capture
    check(busy_o === 1'b1 && line_o === 1'b1, "R2 busy and line high after accept",
          int'(busy_o) * 2 + int'(line_o), 3);
    for (int i = 0; i < n; i++) begin
      bit b = d[n - 1 - i];
      int h = high_len(b, p);
      for (int j = 0; j < p; j++) begin
        start_i = (i == 0 && j == 1);      // R3: start during a frame is ignored
        if (line_o !== (j < h) || busy_o !== 1'b1) begin
          if (bad == 0) begin
            first_act = int'(line_o);
            first_exp = int'(j < h);
          end
          bad++;
        end
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    check(bad == 0, "R3 R4 R5 R6 R7 R9 frame waveform", first_act, first_exp);
    check(done_o === 1'b1 && busy_o === 1'b0 && line_o === 1'b0,
          "R8 done with busy low and line low",
          int'(done_o) * 4 + int'(busy_o) * 2 + int'(line_o), 4);
    @(negedge clk);
    check(done_o === 1'b0, "R8 done lasts one cycle", int'(done_o), 0);
    check(line_o === 1'b0 && busy_o === 1'b0, "R10 idle line low",
          int'(line_o), 0);
  endtask

  task automatic try_ignored(input int n, input int p, input string tag);
    int bad = 0;
    @(negedge clk);
    data_i = DW'($urandom); nbits_i = CW'(n); period_i = PW'(p); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (busy_o !== 1'b0 || line_o !== 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    check(line_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
          "R1 outputs low in reset", int'(line_o | busy_o | done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(line_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
          "R1 outputs low after reset", int'(line_o | busy_o | done_o), 0);

    try_ignored(0, 20, "R3 zero bit count ignored");
    try_ignored(DW + 1, 20, "R3 bit count above width ignored");
    try_ignored(4, 4, "R3 period below five ignored");

    run_frame(16'hFFFF, DW, 5);     // R6 shortest period, all ones
    run_frame(16'h0000, DW, 5);     // R5 shortest period, all zeros
    run_frame(16'h0001, 1, 7);      // single bit
    run_frame(16'hFF00, 4, 10);     // R7 upper bits ignored, sends 0000
    run_frame(16'h000A, 4, 13);     // R7 order 1010
    run_frame(16'hA5C3, DW, 9);

    for (int r = 0; r < 20; r++) begin
      run_frame(DW'($urandom), $urandom_range(1, DW), $urandom_range(5, 40));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule